// File: doc/BRIEF.md
# ADC Capture Bus Peripheral

This peripheral connects a 12-bit analog-to-digital converter to a small processor memory bus. The high byte of a multiplexed address is captured on an address timing pulse, and the captured page selects what the strobes do. When the read strobe falls with the start page selected, the block pulses the converter's start line. When the converter's end-of-conversion line rises, the block stores the sample and raises a ready flag that software polls.

Software then fetches the sample as two bytes. Each byte carries six data bits in its low positions and two mask bits, always zero, in its top positions. The upper half sits on one page and the lower half on another. The bytes are driven while the write strobe is low, because the processor stores bus data into its own memory during that strobe. The block holds the last sample until the next one is captured.

Top module: `adc_capture`

## Requirements
- R1: After reset, adc_start_o and flag_o are 0, rd_data_o is 0x00 and the stored sample is 0.
- R2: A falling edge of mrd_ni while the latched page equals START_PAGE (default 0x0C) and no conversion is pending makes adc_start_o high for exactly one cycle, in the cycle after that edge.
- R3: flag_o goes low in the same cycle that adc_start_o goes high.
- R4: A rising edge of adc_eoc_i while a conversion is pending stores adc_data_i and sets flag_o in the following cycle.
- R5: While mwr_ni is low, rd_data_o is {2'b00, sample[11:6]} with latched page HI_PAGE (default 0x0F) and {2'b00, sample[5:0]} with latched page LO_PAGE (default 0x0E). At all other times it is 0x00. For example, sample 0x666 reads 0x19 high and 0x26 low.
- R6: Bits 7 and 6 of rd_data_o are always 0.
- R7: A read strobe on any page other than START_PAGE, including the two data pages, starts no conversion and leaves flag_o unchanged.
- R8: A start request made while a conversion is pending is ignored. This includes a request in the same cycle as the end-of-conversion edge. No start pulse is produced and the sample captured by that end of conversion is kept.
- R9: The stored sample changes only on a qualifying end-of-conversion edge. An end-of-conversion edge while no conversion is pending has no effect.
- R10: The page changes only in a cycle where tpa_i is high. Address bus activity without tpa_i has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Multiplexed high address byte |
| tpa_i | input | 1 | Address timing pulse; latches addr_i as the page |
| mrd_ni | input | 1 | Memory read strobe, active low |
| mwr_ni | input | 1 | Memory write strobe, active low; data bytes driven during it |
| rd_data_o | output | 8 | Byte presented to the processor data bus |
| adc_start_o | output | 1 | One-cycle start pulse to the converter |
| adc_eoc_i | input | 1 | End-of-conversion from the converter |
| adc_data_i | input | 12 | Converter result |
| flag_o | output | 1 | Sample ready status flag |

## Verification
A start request and an end-of-conversion edge can arrive in the same clock. The bench provokes this by taking over the converter lines from the stub. It drives the end-of-conversion rise and a read-strobe fall on the start page at the same negedge while a conversion is pending. The outcome is judged against a behavioural model: no start pulse, flag set, and the new sample readable on both data pages. A second overlap is a repeated start strobe well inside a long conversion, which also must produce no pulse.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_START,
    SEL_HI,
    SEL_LO
  } page_sel_e;
endpackage

// File: rtl/adc_cap_decode.sv
module adc_cap_decode
  import adc_cap_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] START_PAGE = 8'h0C,
  parameter logic [ADDR_W-1:0] HI_PAGE    = 8'h0F,
  parameter logic [ADDR_W-1:0] LO_PAGE    = 8'h0E
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              tpa_i,
  input  logic              mrd_ni,
  input  logic              mwr_ni,
  output logic              start_req_o,
  output logic              hi_rd_o,
  output logic              lo_rd_o
);
  logic [ADDR_W-1:0] page_q;
  logic              mrd_q;
  page_sel_e         sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      mrd_q  <= 1'b1;
    end else begin
      if (tpa_i) page_q <= addr_i;
      mrd_q <= mrd_ni;
    end
  end

  always_comb begin
    if (page_q == START_PAGE)   sel = SEL_START;
    else if (page_q == HI_PAGE) sel = SEL_HI;
    else if (page_q == LO_PAGE) sel = SEL_LO;
    else                        sel = SEL_NONE;
  end

  // read strobe acts on its falling edge only
  assign start_req_o = mrd_q & ~mrd_ni & (sel == SEL_START);
  assign hi_rd_o     = ~mwr_ni & (sel == SEL_HI);
  assign lo_rd_o     = ~mwr_ni & (sel == SEL_LO);

  assert_page_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tpa_i |=> $stable(page_q));
  assert_one_sel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_req_o, hi_rd_o, lo_rd_o}));
endmodule

// File: rtl/adc_cap_seq.sv
module adc_cap_seq #(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_req_i,
  input  logic              eoc_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              start_o,
  output logic              flag_o,
  output logic [DATA_W-1:0] result_o
);
  logic eoc_q, busy_q, start_q, flag_q;
  logic [DATA_W-1:0] result_q;
  logic eoc_rise, done, launch;

  assign eoc_rise = eoc_i & ~eoc_q;
  assign done     = eoc_rise & busy_q;
  assign launch   = start_req_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eoc_q    <= 1'b0;
      busy_q   <= 1'b0;
      start_q  <= 1'b0;
      flag_q   <= 1'b0;
      result_q <= '0;
    end else begin
      eoc_q   <= eoc_i;
      start_q <= launch;
      if (done) begin
        busy_q   <= 1'b0;
        flag_q   <= 1'b1;
        result_q <= data_i;
      end else if (launch) begin
        busy_q <= 1'b1;
        flag_q <= 1'b0;
      end
    end
  end

  assign start_o  = start_q;
  assign flag_o   = flag_q;
  assign result_o = result_q;

  assert_start_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  assert_flag_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !flag_o);
  assert_flag_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoc_rise && busy_q) |=> flag_o);
  assert_busy_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> !start_o);
  assert_result_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(eoc_rise && busy_q) |=> $stable(result_o));
endmodule

// File: rtl/adc_capture.sv
module adc_capture #(
  parameter int               ADDR_W     = 8,
  parameter int               DATA_W     = 12,
  parameter int               MASK_W     = 2,
  parameter logic [ADDR_W-1:0] START_PAGE = 8'h0C,
  parameter logic [ADDR_W-1:0] HI_PAGE    = 8'h0F,
  parameter logic [ADDR_W-1:0] LO_PAGE    = 8'h0E,
  localparam int              HALF_W     = DATA_W / 2,
  localparam int              BYTE_W     = HALF_W + MASK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              tpa_i,
  input  logic              mrd_ni,
  input  logic              mwr_ni,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              adc_start_o,
  input  logic              adc_eoc_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic              flag_o
);
  logic              start_req, hi_rd, lo_rd;
  logic [DATA_W-1:0] result;

  adc_cap_decode #(
    .ADDR_W    (ADDR_W),
    .START_PAGE(START_PAGE),
    .HI_PAGE   (HI_PAGE),
    .LO_PAGE   (LO_PAGE)
  ) u_decode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .tpa_i      (tpa_i),
    .mrd_ni     (mrd_ni),
    .mwr_ni     (mwr_ni),
    .start_req_o(start_req),
    .hi_rd_o    (hi_rd),
    .lo_rd_o    (lo_rd)
  );

  adc_cap_seq #(
    .DATA_W(DATA_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_req_i(start_req),
    .eoc_i      (adc_eoc_i),
    .data_i     (adc_data_i),
    .start_o    (adc_start_o),
    .flag_o     (flag_o),
    .result_o   (result)
  );

  always_comb begin
    rd_data_o = '0;
    if (hi_rd)      rd_data_o = {{MASK_W{1'b0}}, result[DATA_W-1:HALF_W]};
    else if (lo_rd) rd_data_o = {{MASK_W{1'b0}}, result[HALF_W-1:0]};
  end

  assert_mask_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[BYTE_W-1:HALF_W] == '0);
  assert_quiet_bus_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mwr_ni |-> (rd_data_o == '0));
endmodule

// File: tb/adc_capture_tb.sv
module adc_capture_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam logic [7:0] PG_START = 8'h0C;
  localparam logic [7:0] PG_HI    = 8'h0F;
  localparam logic [7:0] PG_LO    = 8'h0E;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic        tpa = 1'b0, mrd_n = 1'b1, mwr_n = 1'b1;
  logic        adc_eoc = 1'b0;
  logic [11:0] adc_data = 12'h000;
  logic [7:0]  rd_data;
  logic        adc_start, flag;

  int vectors = 0, miscompares = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_capture dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .tpa_i(tpa),
    .mrd_ni(mrd_n), .mwr_ni(mwr_n), .rd_data_o(rd_data),
    .adc_start_o(adc_start), .adc_eoc_i(adc_eoc), .adc_data_i(adc_data),
    .flag_o(flag)
  );

  // behavioural reference
  logic [7:0]  m_page;
  logic        m_mrd_q, m_eoc_q, m_busy, m_start, m_flag;
  logic [11:0] m_res;
  logic        m_req, m_rise;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_page <= 8'h00; m_mrd_q <= 1'b1; m_eoc_q <= 1'b0;
      m_busy <= 1'b0; m_start <= 1'b0; m_flag <= 1'b0; m_res <= 12'h000;
    end else begin
      m_req  = m_mrd_q && !mrd_n && (m_page == PG_START);
      m_rise = adc_eoc && !m_eoc_q;
      m_mrd_q <= mrd_n;
      m_eoc_q <= adc_eoc;
      if (tpa) m_page <= addr;
      m_start <= m_req && !m_busy;
      if (m_rise && m_busy) begin
        m_busy <= 1'b0; m_flag <= 1'b1; m_res <= adc_data;
      end else if (m_req && !m_busy) begin
        m_busy <= 1'b1; m_flag <= 1'b0;
      end
    end
  end

  function automatic logic [7:0] exp_byte();
    if (!mwr_n && m_page == PG_HI) return {2'b00, m_res[11:6]};
    if (!mwr_n && m_page == PG_LO) return {2'b00, m_res[5:0]};
    return 8'h00;
  endfunction

  // converter stub
  logic        stub_en = 1'b1;
  int          conv_delay = 5;
  int          stub_cnt = 0;
  logic [11:0] samples[$];

  always @(negedge clk) begin
    if (stub_en) begin
      adc_eoc = 1'b0;
      if (stub_cnt > 0) begin
        stub_cnt--;
        if (stub_cnt == 0) begin
          adc_eoc  = 1'b1;
          adc_data = (samples.size() > 0) ? samples.pop_front() : 12'h000;
        end
      end
      if (adc_start) stub_cnt = conv_delay;
    end
  end

  task automatic compare();
    logic [7:0] eb;
    eb = exp_byte();
    vectors++;
    if (adc_start !== m_start || flag !== m_flag || rd_data !== eb) begin
      miscompares++;
      $display("FAIL %s: start/flag/data actual %b/%b/%h expected %b/%b/%h",
               cur_req, adc_start, flag, rd_data, m_start, m_flag, eb);
    end
  endtask

  task automatic check_eq(string req, logic [11:0] act, logic [11:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    #1 compare();
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic set_page(logic [7:0] p);
    addr = p; tpa = 1'b1; tick();
    tpa = 1'b0; addr = 8'hA5; tick();
  endtask

  task automatic rd_strobe();
    mrd_n = 1'b0; tick();
    mrd_n = 1'b1; tick();
  endtask

  task automatic read_byte(logic [7:0] p, logic [7:0] exp, string req);
    set_page(p);
    mwr_n = 1'b0;
    #1 check_eq(req, {4'h0, rd_data}, {4'h0, exp});
    tick();
    mwr_n = 1'b1; tick();
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    cur_req = "R1";
    check_eq("R1", {10'h0, adc_start, flag}, 12'h000);
    check_eq("R1", {4'h0, rd_data}, 12'h000);
    tick();
    rst_ni = 1'b1;
    tick();

    // R2 R3 R4 R5: conversion and split readout of 0x666
    cur_req = "R2";
    samples.push_back(12'h666);
    conv_delay = 5;
    set_page(PG_START);
    rd_strobe();
    cur_req = "R4";
    idle(10);
    check_eq("R4", {11'h0, flag}, 12'h001);
    cur_req = "R5";
    read_byte(PG_HI, 8'h19, "R5");
    read_byte(PG_LO, 8'h26, "R5");

    // R7: strobes on data pages and a foreign page start nothing
    cur_req = "R7";
    set_page(PG_HI); rd_strobe(); idle(8);
    set_page(8'h33); rd_strobe(); idle(8);
    check_eq("R7", {11'h0, flag}, 12'h001);

    // R10: start page on the bus without tpa is not latched
    cur_req = "R10";
    set_page(PG_LO);
    addr = PG_START; tick();
    rd_strobe(); idle(8);
    check_eq("R10", {11'h0, flag}, 12'h001);

    // R8: second start during a long conversion is ignored
    cur_req = "R8";
    samples.push_back(12'hABC);
    conv_delay = 20;
    set_page(PG_START);
    rd_strobe(); idle(4); rd_strobe();
    idle(25);
    check_eq("R8", {11'h0, flag}, 12'h001);
    read_byte(PG_HI, 8'h2A, "R8");
    read_byte(PG_LO, 8'h3C, "R8");

    // R9: end of conversion while idle has no effect
    cur_req = "R9";
    idle(2);
    stub_en = 1'b0;
    adc_data = 12'hFFF; adc_eoc = 1'b1; tick();
    adc_eoc = 1'b0; tick();
    read_byte(PG_HI, 8'h2A, "R9");
    read_byte(PG_LO, 8'h3C, "R9");

    // R8: start request in the same cycle as end of conversion
    cur_req = "R8";
    set_page(PG_START);
    rd_strobe(); idle(3);
    adc_data = 12'h5A5; adc_eoc = 1'b1; mrd_n = 1'b0; tick();
    adc_eoc = 1'b0; mrd_n = 1'b1; tick();
    idle(3);
    check_eq("R8", {11'h0, flag}, 12'h001);
    read_byte(PG_HI, 8'h16, "R8");
    read_byte(PG_LO, 8'h25, "R8");

    // R6: full-scale sample keeps mask bits clear
    cur_req = "R6";
    stub_en = 1'b1;
    samples.push_back(12'hFFF);
    conv_delay = 3;
    set_page(PG_START);
    rd_strobe(); idle(8);
    read_byte(PG_HI, 8'h3F, "R6");
    read_byte(PG_LO, 8'h3F, "R6");

    idle(4);
    finish_run();
  end
endmodule